// File: doc/BRIEF.md
# Host Receive Queue with Per-Byte Error Tags

This block is the receive half of a parallel interface that looks like a 16550-style UART to a host processor. It has no serial line. A controller on the device side first writes three error flags (parity, framing, break) into a shadow status register. It then writes the data byte. The block stages the flags and stores them next to the byte as one 11-bit queue entry.

The host reads bytes from the head of the queue. It reads a line-status byte to get the flags of the entry currently at the head, together with summary bits:

- data present
- overrun
- an errored entry somewhere in the queue

With these, the host can alternate a status read and a data read for every byte. A host that sees no errors can simply read a burst of bytes.

Four interrupt requests come out as separate levels:

- data present
- fill level at or above a selectable trigger
- character timeout
- line error

Top module: `mimic_rx_path`

## Requirements
- R1: Entries leave in the order they were written. `host_data` shows the head byte. `host_lsr[4:2]` show the head's flags as {break, framing, parity}, where parity is bit 2. These bits read 0 when the queue is empty.
- R2: A shadow write stages `ctl_err_flags` for the next data write. A data write stores the staged flags with the byte and then clears the staging to 0. If a shadow write and a data write occur in the same cycle, the byte takes the flags from that shadow write.
- R3: `host_lsr[0]` and `irq_data_ready` are 1 exactly when the queue holds at least one entry.
- R4: The queue holds DEPTH entries (16). A data write to a full queue with no read in the same cycle is discarded and sets `host_lsr[1]` (overrun). Overrun stays set until a host line-status read, and is not cleared by a data read.
- R5: A data write and a host data read in the same cycle on a full queue both take effect, so the queue stays full and the new byte is kept.
- R6: `host_lsr[7]` is 1 exactly when at least one stored entry has a nonzero flag field. It clears by itself once the last such entry has been read.
- R7: `irq_trigger` is 1 when the entry count is at or above the level that `trig_sel` selects: 0 selects 1, 1 selects 4, 2 selects 8, 3 selects 14.
- R8: `irq_timeout` rises after `tmo_limit`+1 consecutive clock edges on which the queue is non-empty and there is neither a data write nor a host data read. Any data write restarts the count without clearing the flag. A host data read clears the flag.
- R9: `irq_line_err` is 1 when overrun is set or when the head entry (queue non-empty) has a nonzero flag field.
- R10: After reset the queue is empty, `host_lsr` is 0, the staging holds 0 and every interrupt output is 0.
- R11: A host data read on an empty queue has no effect. The status stays 0, and a byte written afterwards is returned intact.
- R12: `host_lsr[6:5]` always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_stat_we | input | 1 | Controller shadow status write strobe |
| ctl_err_flags | input | 3 | Error flags {break, framing, parity} |
| ctl_data_we | input | 1 | Controller data write strobe |
| ctl_data | input | 8 | Received byte |
| host_rd_data | input | 1 | Host pops the head byte |
| host_rd_lsr | input | 1 | Host line-status read (clears overrun) |
| trig_sel | input | 2 | Trigger level select |
| tmo_limit | input | TMO_W | Idle-cycle timeout limit |
| host_data | output | 8 | Head byte |
| host_lsr | output | 8 | Line status byte |
| irq_data_ready | output | 1 | Queue non-empty request |
| irq_trigger | output | 1 | Trigger-level request |
| irq_timeout | output | 1 | Character timeout request |
| irq_line_err | output | 1 | Line error request |

## Verification
Four pairs of operations can land on the same edge:

- **Host data read and controller data write on a full queue.** The bench fills all sixteen slots and then issues both strobes together. A reference queue in the bench expects the count to stay at sixteen, the new byte to be kept at the tail, and no overrun.
- **Shadow write and data write.** These are driven in one cycle, and the bench expects the byte to carry the flags written in that same cycle.
- **Discarded write and line-status read.** Overrun must be set by the discarded write and survive a data read, and is cleared only by a status read.
- **Data write during a pending timeout.** The write must restart the idle count while the raised timeout holds until the next host data read.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
    localparam int FLAG_W = 3;
    localparam int BYTE_W = 8;

    typedef logic [FLAG_W-1:0] err_flags_t;

    typedef struct packed {
        err_flags_t        flags;
        logic [BYTE_W-1:0] data;
    } rx_entry_t;

    localparam int ENTRY_W = $bits(rx_entry_t);
endpackage

// File: rtl/mrx_stage.sv
module mrx_stage
    import mrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stat_we,
    input  err_flags_t stat_flags,
    input  logic       data_we,
    output err_flags_t tag_flags
);
    typedef struct packed {
        err_flags_t staged;
    } stage_state_t;

    stage_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        tag_flags = stat_we ? stat_flags : s_q.staged;
        if (data_we)
            s_d.staged = '0;
        else if (stat_we)
            s_d.staged = stat_flags;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2
    stage_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && !data_we) |=> (s_q.staged == $past(stat_flags)));

    // R2
    stage_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_we |=> (s_q.staged == '0));
endmodule

// File: rtl/mrx_fifo.sv
module mrx_fifo
    import mrx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  rx_entry_t        push_entry,
    input  logic             pop_req,
    output rx_entry_t        head,
    output logic [CNT_W-1:0] count,
    output logic             err_any,
    output logic             dropped
);
    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] err_cnt;
    } fifo_state_t;

    fifo_state_t s_d, s_q;
    rx_entry_t   mem [DEPTH];
    logic        do_pop, do_push, is_full;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        s_d     = s_q;
        head    = mem[s_q.rd_ptr];
        is_full = (s_q.cnt == CNT_W'(DEPTH));
        do_pop  = pop_req && (s_q.cnt != '0);
        do_push = push_req && (!is_full || do_pop);
        dropped = push_req && !do_push;

        if (do_push) s_d.wr_ptr = ptr_inc(s_q.wr_ptr);
        if (do_pop)  s_d.rd_ptr = ptr_inc(s_q.rd_ptr);

        s_d.cnt = s_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        s_d.err_cnt = s_q.err_cnt
                    + CNT_W'(do_push && (push_entry.flags != '0))
                    - CNT_W'(do_pop && (head.flags != '0));

        count   = s_q.cnt;
        err_any = (s_q.err_cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[s_q.wr_ptr] <= push_entry;
    end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(DEPTH));

    // R6
    err_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.err_cnt <= s_q.cnt);

    // R4
    drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !pop_req && s_q.cnt == CNT_W'(DEPTH)) |=> $stable(s_q.cnt));

    // R5
    full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req && s_q.cnt == CNT_W'(DEPTH)) |=> (s_q.cnt == CNT_W'(DEPTH)));

    // R11
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req && s_q.cnt == '0) |=> (s_q.cnt == '0));
endmodule

// File: rtl/mrx_idle_timer.sv
module mrx_idle_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             activity,
    input  logic             host_pop,
    input  logic             nonempty,
    input  logic [TMO_W-1:0] limit,
    output logic             timeout
);
    typedef struct packed {
        logic [TMO_W-1:0] idle;
        logic             tmo;
    } tmr_state_t;

    tmr_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (activity || !nonempty)
            s_d.idle = '0;
        else if (s_q.idle != limit)
            s_d.idle = s_q.idle + TMO_W'(1);

        if (host_pop)
            s_d.tmo = 1'b0;
        else if (nonempty && !activity && (s_q.idle == limit))
            s_d.tmo = 1'b1;

        timeout = s_q.tmo;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R8
    tmo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_pop |=> !timeout);

    // R8
    tmo_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> ($past(nonempty) && !$past(activity)));
endmodule

// File: rtl/mimic_rx_path.sv
module mimic_rx_path
    import mrx_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int TMO_W  = 16,
    parameter int TRIG_0 = 1,
    parameter int TRIG_1 = 4,
    parameter int TRIG_2 = 8,
    parameter int TRIG_3 = 14,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_stat_we,
    input  logic [2:0]       ctl_err_flags,
    input  logic             ctl_data_we,
    input  logic [7:0]       ctl_data,
    input  logic             host_rd_data,
    input  logic             host_rd_lsr,
    input  logic [1:0]       trig_sel,
    input  logic [TMO_W-1:0] tmo_limit,
    output logic [7:0]       host_data,
    output logic [7:0]       host_lsr,
    output logic             irq_data_ready,
    output logic             irq_trigger,
    output logic             irq_timeout,
    output logic             irq_line_err
);
    typedef struct packed {
        logic ovr;
    } top_state_t;

    top_state_t       s_d, s_q;
    err_flags_t       tag_flags;
    rx_entry_t        new_entry, head;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] trig_level;
    logic             err_any, dropped, nonempty;
    err_flags_t       head_flags;

    mrx_stage u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_we    (ctl_stat_we),
        .stat_flags (ctl_err_flags),
        .data_we    (ctl_data_we),
        .tag_flags  (tag_flags)
    );

    always_comb begin
        new_entry.flags = tag_flags;
        new_entry.data  = ctl_data;
    end

    mrx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_req   (ctl_data_we),
        .push_entry (new_entry),
        .pop_req    (host_rd_data),
        .head       (head),
        .count      (count),
        .err_any    (err_any),
        .dropped    (dropped)
    );

    mrx_idle_timer #(.TMO_W(TMO_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .activity (ctl_data_we || host_rd_data),
        .host_pop (host_rd_data),
        .nonempty (nonempty),
        .limit    (tmo_limit),
        .timeout  (irq_timeout)
    );

    always_comb begin
        s_d = s_q;
        if (dropped)
            s_d.ovr = 1'b1;
        else if (host_rd_lsr)
            s_d.ovr = 1'b0;

        unique case (trig_sel)
            2'd0:    trig_level = CNT_W'(TRIG_0);
            2'd1:    trig_level = CNT_W'(TRIG_1);
            2'd2:    trig_level = CNT_W'(TRIG_2);
            default: trig_level = CNT_W'(TRIG_3);
        endcase

        nonempty       = (count != '0);
        head_flags     = nonempty ? head.flags : '0;
        host_data      = head.data;
        host_lsr       = {err_any, 2'b00, head_flags, s_q.ovr, nonempty};
        irq_data_ready = nonempty;
        irq_trigger    = (count >= trig_level);
        irq_line_err   = s_q.ovr || (head_flags != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dropped |=> host_lsr[1]);

    // R4
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_lsr && !dropped) |=> !host_lsr[1]);

    // R3
    ready_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_data_we && !host_rd_data) |=> irq_data_ready);
endmodule

// File: tb/tb_mimic_rx_path.sv
`timescale 1ns/1ps
module tb_mimic_rx_path;
    localparam int DEPTH = 16;
    localparam int TMO_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctl_stat_we = 1'b0;
    logic [2:0]       ctl_err_flags = '0;
    logic             ctl_data_we = 1'b0;
    logic [7:0]       ctl_data = '0;
    logic             host_rd_data = 1'b0;
    logic             host_rd_lsr = 1'b0;
    logic [1:0]       trig_sel = '0;
    logic [TMO_W-1:0] tmo_limit = '1;
    logic [7:0]       host_data;
    logic [7:0]       host_lsr;
    logic             irq_data_ready, irq_trigger, irq_timeout, irq_line_err;

    mimic_rx_path #(.DEPTH(DEPTH), .TMO_W(TMO_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .ctl_stat_we(ctl_stat_we), .ctl_err_flags(ctl_err_flags),
        .ctl_data_we(ctl_data_we), .ctl_data(ctl_data),
        .host_rd_data(host_rd_data), .host_rd_lsr(host_rd_lsr),
        .trig_sel(trig_sel), .tmo_limit(tmo_limit),
        .host_data(host_data), .host_lsr(host_lsr),
        .irq_data_ready(irq_data_ready), .irq_trigger(irq_trigger),
        .irq_timeout(irq_timeout), .irq_line_err(irq_line_err)
    );

    always #2 clk = ~clk;

    int         n_chk = 0;
    int         n_err = 0;
    bit         done = 1'b0;
    logic [10:0] mq[$];
    logic        m_ovr = 1'b0;
    logic [2:0]  m_stage = '0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int lvl(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic check_all(input string ctx);
        bit         ne;
        bit         eany;
        logic [2:0] hf;
        logic [7:0] lsr_e;
        ne   = (mq.size() != 0);
        eany = 1'b0;
        foreach (mq[i]) if (mq[i][10:8] != 3'b000) eany = 1'b1;
        hf    = ne ? mq[0][10:8] : 3'b000;
        lsr_e = {eany, 2'b00, hf, m_ovr, ne};
        chk({ctx, " R1 head flags"}, int'(host_lsr[4:2]), int'(hf));
        if (ne) chk({ctx, " R1 head data"}, int'(host_data), int'(mq[0][7:0]));
        chk({ctx, " R3 ready"}, int'({irq_data_ready, host_lsr[0]}), int'({ne, ne}));
        chk({ctx, " R4 overrun"}, int'(host_lsr[1]), int'(m_ovr));
        chk({ctx, " R6 err any"}, int'(host_lsr[7]), int'(eany));
        chk({ctx, " R12 lsr"}, int'(host_lsr), int'(lsr_e));
        chk({ctx, " R7 trigger"}, int'(irq_trigger), int'(mq.size() >= lvl(trig_sel)));
        chk({ctx, " R9 line err"}, int'(irq_line_err), int'(m_ovr || (hf != 3'b000)));
    endtask

    task automatic cyc(input bit sw, input logic [2:0] sf, input bit dw, input logic [7:0] d,
                       input bit rd, input bit lr, input string ctx);
        bit         full;
        bit         pop;
        bit         drop;
        logic [2:0] tag;
        ctl_stat_we = sw; ctl_err_flags = sf; ctl_data_we = dw; ctl_data = d;
        host_rd_data = rd; host_rd_lsr = lr;
        @(posedge clk);
        #1;
        full = (mq.size() == DEPTH);
        pop  = rd && (mq.size() != 0);
        tag  = sw ? sf : m_stage;
        drop = 1'b0;
        if (pop) void'(mq.pop_front());
        if (dw) begin
            if (!full || pop) mq.push_back({tag, d});
            else drop = 1'b1;
        end
        if (dw) m_stage = 3'b000;
        else if (sw) m_stage = sf;
        if (drop) m_ovr = 1'b1;
        else if (lr) m_ovr = 1'b0;
        ctl_stat_we = 1'b0; ctl_data_we = 1'b0; host_rd_data = 1'b0; host_rd_lsr = 1'b0;
        check_all(ctx);
    endtask

    task automatic push_tagged(input logic [2:0] f, input logic [7:0] d, input string ctx);
        cyc(1'b1, f, 1'b0, 8'h00, 1'b0, 1'b0, ctx);
        cyc(1'b0, 3'b000, 1'b1, d, 1'b0, 1'b0, ctx);
    endtask

    task automatic drain(input string ctx);
        while (mq.size() != 0) cyc(1'b0, 3'b000, 1'b0, 8'h00, 1'b1, 1'b0, ctx);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        check_all("R10 reset");
        chk("R10 timeout", int'(irq_timeout), 0);

        // R2: staged, same-cycle, and untagged writes
        push_tagged(3'b101, 8'hA5, "R2 staged");
        cyc(1'b1, 3'b010, 1'b1, 8'h3C, 1'b0, 1'b0, "R2 same cycle");
        cyc(1'b0, 3'b000, 1'b1, 8'h77, 1'b0, 1'b0, "R2 cleared stage");
        // R1: alternate status read and data read
        for (int i = 0; i < 3; i++) begin
            cyc(1'b0, 3'b000, 1'b0, 8'h00, 1'b0, 1'b1, "R1 lsr read");
            cyc(1'b0, 3'b000, 1'b0, 8'h00, 1'b1, 1'b0, "R1 pop");
        end

        // R11: read on empty
        cyc(1'b0, 3'b000, 1'b0, 8'h00, 1'b1, 1'b0, "R11 empty read");
        cyc(1'b0, 3'b000, 1'b1, 8'hE1, 1'b0, 1'b0, "R11 after empty read");
        drain("R11 drain");

        // R4 / R6: fill with an arithmetic flag pattern
        for (int i = 0; i < DEPTH; i++) begin
            logic [2:0] f;
            f = (i % 4 == 1) ? 3'((i * 3) % 8) : 3'b000;
            push_tagged(f, 8'(i * 29 + 7), "R4 fill");
        end
        cyc(1'b0, 3'b000, 1'b1, 8'hEE, 1'b0, 1'b0, "R4 write when full");
        cyc(1'b0, 3'b000, 1'b1, 8'h5A, 1'b1, 1'b0, "R5 swap when full");
        cyc(1'b0, 3'b000, 1'b0, 8'h00, 1'b1, 1'b0, "R4 data read keeps overrun");
        cyc(1'b0, 3'b000, 1'b0, 8'h00, 1'b0, 1'b1, "R4 lsr read clears");
        cyc(1'b1, 3'b100, 1'b1, 8'hB7, 1'b0, 1'b1, "R5 refill");
        cyc(1'b0, 3'b000, 1'b1, 8'hC8, 1'b0, 1'b1, "R4 drop beats lsr read");
        cyc(1'b0, 3'b000, 1'b0, 8'h00, 1'b0, 1'b1, "R4 lsr read");
        drain("R6 drain");

        // R7: trigger sweep over every select and every fill level
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            #1;
            check_all("R7 empty");
            for (int n = 1; n <= DEPTH; n++)
                cyc(1'b0, 3'b000, 1'b1, 8'(n * 11 + s), 1'b0, 1'b0, "R7 sweep");
            drain("R7 drain");
        end
        trig_sel = 2'd0;

        // R8: timeout
        tmo_limit = 16'd3;
        cyc(1'b0, 3'b000, 1'b1, 8'h42, 1'b0, 1'b0, "R8 push");
        chk("R8 after push", int'(irq_timeout), 0);
        for (int k = 1; k <= 4; k++) begin
            cyc(1'b0, 3'b000, 1'b0, 8'h00, 1'b0, 1'b0, "R8 idle");
            chk("R8 idle count", int'(irq_timeout), int'(k >= 4));
        end
        cyc(1'b0, 3'b000, 1'b1, 8'h43, 1'b0, 1'b0, "R8 write holds");
        chk("R8 write holds flag", int'(irq_timeout), 1);
        cyc(1'b0, 3'b000, 1'b0, 8'h00, 1'b1, 1'b0, "R8 read clears");
        chk("R8 read clears flag", int'(irq_timeout), 0);
        for (int k = 0; k < 2; k++) cyc(1'b0, 3'b000, 1'b0, 8'h00, 1'b0, 1'b0, "R8 idle");
        cyc(1'b0, 3'b000, 1'b1, 8'h44, 1'b0, 1'b0, "R8 restart");
        for (int k = 1; k <= 4; k++) begin
            cyc(1'b0, 3'b000, 1'b0, 8'h00, 1'b0, 1'b0, "R8 idle");
            chk("R8 restarted count", int'(irq_timeout), int'(k >= 4));
        end
        drain("R8 drain");
        chk("R8 cleared at end", int'(irq_timeout), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule